// File: doc/BRIEF.md
# Serial LDPC Node Processing Unit

This block is one processing element of a partly parallel LDPC decoder. Edge messages for a single node arrive one per clock. A flag on the final message closes the node, and the unit then returns one extrinsic message per edge, one per clock, in arrival order. Nodes of any degree up to `MAX_DEG` are handled without reconfiguration. The same datapath serves both half iterations, and a mode bit sampled with the first message of each node picks the function. In variable mode each edge receives the channel LLR plus every other incoming message. In check mode a min-sum update is computed over the information edges and the two zigzag parity edges.

In check mode the check nodes of a group are processed in order. The message a check node produces toward its right-hand parity node has that parity node's channel LLR added to it and is then kept inside the unit. The next check node of the group uses it as its left-hand input. Only the message toward the left-hand parity node leaves the unit for storage, on a separate output strobe. A group-start flag marks a check node that has no left-hand neighbour.

All messages are 6-bit two's-complement LLRs. Results saturate to the symmetric range ±31.

Top module: `ldpc_node_unit`

## Requirements
- R1: After reset, `in_ready` is 1 and both `out_valid` and `bwd_valid` are 0.
- R2: A message is taken on every clock edge where `in_valid` and `in_ready` are both 1. Bubbles with `in_valid` at 0 are ignored, including any `in_last` value driven during them. `in_ready` is 0 from the edge that takes a message flagged `in_last` until the node's outputs are complete.
- R3: When the last message of a node of degree d is taken at edge E, outputs appear after edges E+1 through E+d with `out_valid` at 1, one per edge, in arrival order. `out_last` is 1 only on the final output, and `in_ready` returns to 1 after edge E+d.
- R4: With `node_kind` = 0 (variable), the output for edge i is `ch_llr` + Σ(all messages) − message i.
- R5: Every output value (`out_msg`, `bwd_msg` and the carried forward value) saturates to the range −31..+31. The code −32 never appears.
- R6: With `node_kind` = 1 (check), the output for information edge i has a magnitude equal to the minimum magnitude over all other edges of the node. Those edges are the other information edges, the left edge (when present) and the right edge `par_rt`. The output is negative exactly when an odd number of those other edges are negative. A zero counts as non-negative.
- R7: In check mode, `bwd_valid` pulses together with the node's first output. `bwd_msg` then carries the min-sum result over all information edges and the right edge, which is the message toward the left parity node. Variable nodes never pulse `bwd_valid`.
- R8: After each check node, the carried value becomes saturate(`par_ch` + min-sum over all information edges and the left edge). The next check node uses it as its left edge. Variable nodes leave the carried value unchanged.
- R9: A check node with `grp_first` = 1 has no left edge, so the left edge takes no part in any of its results. The carried value is cleared to zero before this node's own forward result replaces it.
- R10: `node_kind`, `ch_llr`, `grp_first`, `par_rt` and `par_ch` are sampled only with the first message of a node. Their values on later messages have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Incoming message present |
| in_ready | output | 1 | Unit can take a message this cycle |
| in_msg | input | MSG_W | Incoming edge LLR |
| in_last | input | 1 | Marks the final message of a node |
| node_kind | input | 1 | 0 = variable node, 1 = check node (first message only) |
| ch_llr | input | MSG_W | Channel LLR of a variable node (first message only) |
| grp_first | input | 1 | Check node has no left neighbour (first message only) |
| par_rt | input | MSG_W | LLR arriving on the right parity edge (first message only) |
| par_ch | input | MSG_W | Channel LLR of the right parity node (first message only) |
| out_valid | output | 1 | Extrinsic output present |
| out_msg | output | MSG_W | Extrinsic LLR for the current edge |
| out_last | output | 1 | Final output of a node |
| bwd_valid | output | 1 | Message toward the left parity node present |
| bwd_msg | output | MSG_W | Message toward the left parity node |

## Verification
The assertions take two things for granted about the inputs. No LLR input carries the code −32, and a node sends `in_last` by its `MAX_DEG`-th message, so the edge store never overflows. The bench builds every message and side value in the range ±31 and keeps node degrees between 1 and `MAX_DEG`. On non-first messages, and during bubbles, it drives deliberately wrong side inputs and stray `in_last` values. Each extrinsic value is predicted by brute-force exclusion in the bench and compared as it appears. The gap between the last message and the return of `in_ready` is also checked.

// File: rtl/ldpc_nu_pkg.sv
// Shared types of the serial LDPC node unit.
// Assumes: nothing beyond IEEE 1800-2017 enums.
package ldpc_nu_pkg;

    // Function applied to the node currently held in the unit.
    typedef enum logic {
        NODE_VAR = 1'b0,
        NODE_CHK = 1'b1
    } node_kind_e;

    // Collect messages, or return extrinsic results.
    typedef enum logic {
        PH_TAKE = 1'b0,
        PH_EMIT = 1'b1
    } phase_e;

endpackage

// File: rtl/nu_edge_store.sv
// Edge store: keeps the incoming messages of the current node so that
// each edge's own message can be excluded after the last one arrives.
// Assumes: wr_addr and rd_addr stay below DEPTH; data only, no reset.
module nu_edge_store #(
    parameter int MSG_W = 6,
    parameter int DEPTH = 32,
    parameter int AW    = 5
) (
    input  logic             clk,
    input  logic             wr_en,
    input  logic [AW-1:0]    wr_addr,
    input  logic [MSG_W-1:0] wr_data,
    input  logic [AW-1:0]    rd_addr,
    output logic [MSG_W-1:0] rd_data
);

    logic [MSG_W-1:0] slot [DEPTH];

    // Write the accepted message into its arrival slot.
    always_ff @(posedge clk) begin
        for (int k = 0; k < DEPTH; k++) begin
            if (wr_en && (wr_addr == AW'(k))) begin
                slot[k] <= wr_data;
            end
        end
    end

    // Asynchronous read of the edge being emitted.
    assign rd_data = slot[rd_addr];

endmodule

// File: rtl/nu_sum_acc.sv
// Wide accumulator for variable mode: channel LLR plus all messages.
// Assumes: ACC_W is wide enough for MAX_DEG messages plus the channel value.
module nu_sum_acc #(
    parameter int MSG_W = 6,
    parameter int ACC_W = 13
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    en,
    input  logic                    first,
    input  logic signed [MSG_W-1:0] ch,
    input  logic signed [MSG_W-1:0] msg,
    output logic signed [ACC_W-1:0] acc
);

    logic signed [ACC_W-1:0] ch_x;
    logic signed [ACC_W-1:0] msg_x;

    // Sign-extend both operands to the accumulator width.
    assign ch_x  = {{(ACC_W-MSG_W){ch[MSG_W-1]}}, ch};
    assign msg_x = {{(ACC_W-MSG_W){msg[MSG_W-1]}}, msg};

    // Restart with the channel value on the first message, else add.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc <= '0;
        end else if (en) begin
            acc <= first ? (ch_x + msg_x) : (acc + msg_x);
        end
    end

endmodule

// File: rtl/nu_min_track.sv
// Min-sum tracker: smallest and second-smallest magnitude, position of the
// smallest, and parity of the signs over the information edges of a node.
// Assumes: the message code -32 never arrives (magnitude fits MSG_W-1 bits).
module nu_min_track #(
    parameter int MSG_W = 6,
    parameter int IDX_W = 5
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    en,
    input  logic                    first,
    input  logic signed [MSG_W-1:0] msg,
    input  logic [IDX_W-1:0]        idx,
    output logic [MSG_W-2:0]        min1,
    output logic [MSG_W-2:0]        min2,
    output logic [IDX_W-1:0]        min_idx,
    output logic                    sgn_x
);

    localparam int MAGW = MSG_W - 1;

    logic [MSG_W-1:0] neg_v;
    logic [MAGW-1:0]  mag;

    // Magnitude of the incoming message.
    assign neg_v = -msg;
    assign mag   = msg[MSG_W-1] ? neg_v[MAGW-1:0] : msg[MAGW-1:0];

    // Insert the new magnitude into the two-entry sorted minimum list.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            min1    <= '1;
            min2    <= '1;
            min_idx <= '0;
            sgn_x   <= 1'b0;
        end else if (en) begin
            if (first) begin
                min1    <= mag;
                min2    <= '1;
                min_idx <= idx;
                sgn_x   <= msg[MSG_W-1];
            end else begin
                sgn_x <= sgn_x ^ msg[MSG_W-1];
                if (mag < min1) begin
                    min2    <= min1;
                    min1    <= mag;
                    min_idx <= idx;
                end else if (mag < min2) begin
                    min2 <= mag;
                end
            end
        end
    end

endmodule

// File: rtl/nu_out_former.sv
// Output former: builds the extrinsic result of one edge for either node
// kind, plus the backward (left parity) and forward (right parity) results
// of a check node.
// Assumes: left/right LLRs never carry -32; min1/min2 come from nu_min_track.
module nu_out_former
    import ldpc_nu_pkg::*;
#(
    parameter int MSG_W = 6,
    parameter int ACC_W = 13,
    parameter int IDX_W = 5
) (
    input  node_kind_e              kind,
    input  logic signed [ACC_W-1:0] acc,
    input  logic signed [MSG_W-1:0] edge_msg,
    input  logic [IDX_W-1:0]        edge_idx,
    input  logic [MSG_W-2:0]        min1,
    input  logic [MSG_W-2:0]        min2,
    input  logic [IDX_W-1:0]        min_idx,
    input  logic                    sgn_x,
    input  logic signed [MSG_W-1:0] left_msg,
    input  logic                    left_on,
    input  logic signed [MSG_W-1:0] right_msg,
    input  logic signed [MSG_W-1:0] right_ch,
    output logic [MSG_W-1:0]        edge_out,
    output logic [MSG_W-1:0]        bwd_out,
    output logic [MSG_W-1:0]        fwd_out
);

    localparam int MAGW = MSG_W - 1;
    localparam logic signed [ACC_W-1:0] SAT_HI = ACC_W'((2 ** (MSG_W - 1)) - 1);
    localparam logic signed [ACC_W-1:0] SAT_LO = -SAT_HI;

    // Magnitude of a symmetric-range LLR.
    function automatic logic [MAGW-1:0] mag_of(input logic [MSG_W-1:0] v);
        logic [MSG_W-1:0] n;
        n = -v;
        return v[MSG_W-1] ? n[MAGW-1:0] : v[MAGW-1:0];
    endfunction

    // Smaller of two magnitudes.
    function automatic logic [MAGW-1:0] lo(input logic [MAGW-1:0] a, input logic [MAGW-1:0] b);
        return (a < b) ? a : b;
    endfunction

    // Signed LLR from a sign flag and a magnitude.
    function automatic logic [MSG_W-1:0] with_sign(input logic s, input logic [MAGW-1:0] m);
        logic [MSG_W-1:0] p;
        p = {1'b0, m};
        return s ? -p : p;
    endfunction

    // Sign extension to the accumulator width.
    function automatic logic signed [ACC_W-1:0] sx(input logic [MSG_W-1:0] v);
        return {{(ACC_W-MSG_W){v[MSG_W-1]}}, v};
    endfunction

    // Symmetric saturation from the accumulator width to MSG_W.
    function automatic logic [MSG_W-1:0] clip(input logic signed [ACC_W-1:0] v);
        if (v > SAT_HI) begin
            return SAT_HI[MSG_W-1:0];
        end else if (v < SAT_LO) begin
            return SAT_LO[MSG_W-1:0];
        end
        return v[MSG_W-1:0];
    endfunction

    logic [MAGW-1:0]         left_mag;
    logic                    left_neg;
    logic [MAGW-1:0]         right_mag;
    logic                    right_neg;
    logic [MAGW-1:0]         own_rest;
    logic [MAGW-1:0]         chk_mag;
    logic                    chk_neg;
    logic signed [ACC_W-1:0] var_sum;
    logic [MSG_W-1:0]        fwd_ext;

    // Combine tracker state with the two parity edges for every result.
    always_comb begin
        left_mag  = left_on ? mag_of(left_msg) : '1;
        left_neg  = left_on & left_msg[MSG_W-1];
        right_mag = mag_of(right_msg);
        right_neg = right_msg[MSG_W-1];

        own_rest = (edge_idx == min_idx) ? min2 : min1;
        chk_mag  = lo(lo(own_rest, left_mag), right_mag);
        chk_neg  = sgn_x ^ edge_msg[MSG_W-1] ^ left_neg ^ right_neg;

        var_sum  = acc - sx(edge_msg);
        edge_out = (kind == NODE_CHK) ? with_sign(chk_neg, chk_mag) : clip(var_sum);

        bwd_out  = with_sign(sgn_x ^ right_neg, lo(min1, right_mag));
        fwd_ext  = with_sign(sgn_x ^ left_neg, lo(min1, left_mag));
        fwd_out  = clip(sx(right_ch) + sx(fwd_ext));
    end

endmodule

// File: rtl/ldpc_node_unit.sv
// Serial LDPC node unit (top). Takes one edge message per clock until the
// last flag, then returns one extrinsic message per clock. Variable mode:
// channel plus other messages. Check mode: min-sum over the information
// edges and the two zigzag parity edges, with the right-hand result carried
// to the next check node.
// Assumes: MAX_DEG >= 2; last flag by the MAX_DEG-th message; no -32 input.
module ldpc_node_unit
    import ldpc_nu_pkg::*;
#(
    parameter int MSG_W   = 6,
    parameter int MAX_DEG = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic [MSG_W-1:0] in_msg,
    input  logic             in_last,
    input  logic             node_kind,
    input  logic [MSG_W-1:0] ch_llr,
    input  logic             grp_first,
    input  logic [MSG_W-1:0] par_rt,
    input  logic [MSG_W-1:0] par_ch,
    output logic             out_valid,
    output logic [MSG_W-1:0] out_msg,
    output logic             out_last,
    output logic             bwd_valid,
    output logic [MSG_W-1:0] bwd_msg
);

    localparam int IDX_W = $clog2(MAX_DEG);
    localparam int CNT_W = $clog2(MAX_DEG + 1);
    localparam int ACC_W = MSG_W + CNT_W + 1;

    phase_e            ph_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [IDX_W-1:0]  rd_q;
    node_kind_e        kind_q;
    logic [MSG_W-1:0]  left_q;
    logic              left_on_q;
    logic [MSG_W-1:0]  rt_q;
    logic [MSG_W-1:0]  pch_q;
    logic [MSG_W-1:0]  fwd_q;

    logic              take;
    logic              first_beat;
    logic              emit;
    logic              emit_end;
    logic              bwd_slot;

    logic [MSG_W-1:0]  stored_msg;
    logic signed [ACC_W-1:0] acc;
    logic [MSG_W-2:0]  min1;
    logic [MSG_W-2:0]  min2;
    logic [IDX_W-1:0]  min_idx;
    logic              sgn_x;
    logic [MSG_W-1:0]  edge_out;
    logic [MSG_W-1:0]  bwd_out;
    logic [MSG_W-1:0]  fwd_new;

    // Handshake and phase decode.
    assign in_ready   = (ph_q == PH_TAKE);
    assign take       = in_valid && (ph_q == PH_TAKE);
    assign first_beat = take && (cnt_q == '0);
    assign emit       = (ph_q == PH_EMIT);
    assign emit_end   = emit && ((CNT_W'(rd_q) + CNT_W'(1)) == cnt_q);
    assign bwd_slot   = emit && (rd_q == '0) && (kind_q == NODE_CHK);

    nu_edge_store #(
        .MSG_W (MSG_W),
        .DEPTH (MAX_DEG),
        .AW    (IDX_W)
    ) u_store (
        .clk     (clk),
        .wr_en   (take),
        .wr_addr (cnt_q[IDX_W-1:0]),
        .wr_data (in_msg),
        .rd_addr (rd_q),
        .rd_data (stored_msg)
    );

    nu_sum_acc #(
        .MSG_W (MSG_W),
        .ACC_W (ACC_W)
    ) u_acc (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (take),
        .first (first_beat),
        .ch    (ch_llr),
        .msg   (in_msg),
        .acc   (acc)
    );

    nu_min_track #(
        .MSG_W (MSG_W),
        .IDX_W (IDX_W)
    ) u_min (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (take),
        .first   (first_beat),
        .msg     (in_msg),
        .idx     (cnt_q[IDX_W-1:0]),
        .min1    (min1),
        .min2    (min2),
        .min_idx (min_idx),
        .sgn_x   (sgn_x)
    );

    nu_out_former #(
        .MSG_W (MSG_W),
        .ACC_W (ACC_W),
        .IDX_W (IDX_W)
    ) u_form (
        .kind      (kind_q),
        .acc       (acc),
        .edge_msg  (stored_msg),
        .edge_idx  (rd_q),
        .min1      (min1),
        .min2      (min2),
        .min_idx   (min_idx),
        .sgn_x     (sgn_x),
        .left_msg  (left_q),
        .left_on   (left_on_q),
        .right_msg (rt_q),
        .right_ch  (pch_q),
        .edge_out  (edge_out),
        .bwd_out   (bwd_out),
        .fwd_out   (fwd_new)
    );

    // Phase, message count and emit pointer sequencing.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ph_q  <= PH_TAKE;
            cnt_q <= '0;
            rd_q  <= '0;
        end else if (take) begin
            cnt_q <= cnt_q + CNT_W'(1);
            if (in_last) begin
                ph_q <= PH_EMIT;
                rd_q <= '0;
            end
        end else if (emit) begin
            rd_q <= rd_q + IDX_W'(1);
            if (emit_end) begin
                ph_q  <= PH_TAKE;
                cnt_q <= '0;
            end
        end
    end

    // Capture the per-node side inputs with the first message only.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            kind_q    <= NODE_VAR;
            left_q    <= '0;
            left_on_q <= 1'b0;
            rt_q      <= '0;
            pch_q     <= '0;
        end else if (first_beat) begin
            kind_q    <= node_kind_e'(node_kind);
            left_q    <= grp_first ? '0 : fwd_q;
            left_on_q <= ~grp_first;
            rt_q      <= par_rt;
            pch_q     <= par_ch;
        end
    end

    // Carried zigzag value: cleared at a group start, renewed per check node.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fwd_q <= '0;
        end else if (first_beat && node_kind && grp_first) begin
            fwd_q <= '0;
        end else if (bwd_slot) begin
            fwd_q <= fwd_new;
        end
    end

    // Registered extrinsic and backward outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_msg   <= '0;
            out_last  <= 1'b0;
            bwd_valid <= 1'b0;
            bwd_msg   <= '0;
        end else begin
            out_valid <= emit;
            out_last  <= emit_end;
            bwd_valid <= bwd_slot;
            if (emit) begin
                out_msg <= edge_out;
            end
            if (bwd_slot) begin
                bwd_msg <= bwd_out;
            end
        end
    end

endmodule

// File: rtl/ldpc_node_unit_chk.sv
// Checker for ldpc_node_unit: handshake timing, output range and the input
// assumptions the datapath relies on. Attached by bind below.
// Assumes: same parameters as the bound instance.
module ldpc_node_unit_chk #(
    parameter int MSG_W   = 6,
    parameter int MAX_DEG = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic             in_ready,
    input logic [MSG_W-1:0] in_msg,
    input logic             in_last,
    input logic [MSG_W-1:0] ch_llr,
    input logic [MSG_W-1:0] par_rt,
    input logic [MSG_W-1:0] par_ch,
    input logic             out_valid,
    input logic [MSG_W-1:0] out_msg,
    input logic             out_last,
    input logic             bwd_valid,
    input logic [MSG_W-1:0] bwd_msg
);

    localparam int CNT_W = $clog2(MAX_DEG + 1);
    localparam logic [MSG_W-1:0] MOST_NEG = {1'b1, {(MSG_W-1){1'b0}}};

    logic [CNT_W-1:0] beats_q;
    logic             acc_any;
    logic             acc_last;

    assign acc_any  = in_valid && in_ready;
    assign acc_last = acc_any && in_last;

    // Count messages accepted for the node in progress.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            beats_q <= '0;
        end else if (acc_any) begin
            beats_q <= in_last ? '0 : beats_q + CNT_W'(1);
        end
    end

    a_r2_hold_after_last: assert property (@(posedge clk) disable iff (!rst_n)
        acc_last |=> !in_ready);

    a_r2_degree_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_any && !in_last) |-> (beats_q < CNT_W'(MAX_DEG - 1)));

    a_r3_first_output: assert property (@(posedge clk) disable iff (!rst_n)
        acc_last |-> ##2 out_valid);

    a_r3_ready_on_last_out: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_last) |-> in_ready);

    a_r3_last_is_valid: assert property (@(posedge clk) disable iff (!rst_n)
        out_last |-> out_valid);

    a_r5_out_symmetric: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_msg != MOST_NEG));

    a_r5_bwd_symmetric: assert property (@(posedge clk) disable iff (!rst_n)
        bwd_valid |-> (bwd_msg != MOST_NEG));

    a_r7_bwd_with_output: assert property (@(posedge clk) disable iff (!rst_n)
        bwd_valid |-> out_valid);

    a_r6_msg_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        acc_any |-> (in_msg != MOST_NEG));

    a_r10_side_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_any && (beats_q == '0)) |->
            ((ch_llr != MOST_NEG) && (par_rt != MOST_NEG) && (par_ch != MOST_NEG)));

endmodule

bind ldpc_node_unit ldpc_node_unit_chk #(
    .MSG_W   (MSG_W),
    .MAX_DEG (MAX_DEG)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_msg    (in_msg),
    .in_last   (in_last),
    .ch_llr    (ch_llr),
    .par_rt    (par_rt),
    .par_ch    (par_ch),
    .out_valid (out_valid),
    .out_msg   (out_msg),
    .out_last  (out_last),
    .bwd_valid (bwd_valid),
    .bwd_msg   (bwd_msg)
);

// File: tb/ldpc_node_unit_test.sv
// Bench for ldpc_node_unit: behavioural reference with queues, compared on
// every clock at the falling edge.
module ldpc_node_unit_test;

    localparam int MW = 6;
    localparam int MD = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic          in_ready;
    logic [MW-1:0] in_msg = '0;
    logic          in_last = 1'b0;
    logic          node_kind = 1'b0;
    logic [MW-1:0] ch_llr = '0;
    logic          grp_first = 1'b0;
    logic [MW-1:0] par_rt = '0;
    logic [MW-1:0] par_ch = '0;
    logic          out_valid;
    logic [MW-1:0] out_msg;
    logic          out_last;
    logic          bwd_valid;
    logic [MW-1:0] bwd_msg;

    always #5 clk = ~clk;

    ldpc_node_unit #(.MSG_W(MW), .MAX_DEG(MD)) uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_ready  (in_ready),
        .in_msg    (in_msg),
        .in_last   (in_last),
        .node_kind (node_kind),
        .ch_llr    (ch_llr),
        .grp_first (grp_first),
        .par_rt    (par_rt),
        .par_ch    (par_ch),
        .out_valid (out_valid),
        .out_msg   (out_msg),
        .out_last  (out_last),
        .bwd_valid (bwd_valid),
        .bwd_msg   (bwd_msg)
    );

    int    n_chk = 0;
    int    n_fail = 0;
    bit    done = 0;
    string cur_req = "R4";
    int    exp_out[$];
    bit    exp_last[$];
    int    exp_bwd[$];
    int    ref_fwd = 0;

    function automatic int clip6(int v);
        if (v > 31) return 31;
        if (v < -31) return -31;
        return v;
    endfunction

    function automatic int absv(int v);
        return (v < 0) ? -v : v;
    endfunction

    function automatic int minv(int a, int b);
        return (a < b) ? a : b;
    endfunction

    function automatic int s6(logic [MW-1:0] v);
        return int'($signed(v));
    endfunction

    function automatic int gen(int i, int k);
        return ((i * k + 11) % 63) - 31;
    endfunction

    task automatic check(bit ok, string req, string what, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Compare outputs against the reference queues at every falling edge.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (out_valid) begin
                if (exp_out.size() == 0) begin
                    check(1'b0, "R3", "unexpected output", s6(out_msg), 0);
                end else begin
                    int e;
                    bit l;
                    e = exp_out.pop_front();
                    l = exp_last.pop_front();
                    check(s6(out_msg) == e, cur_req, "out_msg", s6(out_msg), e);
                    check(out_last == l, "R3", "out_last", int'(out_last), int'(l));
                end
            end
            if (bwd_valid) begin
                if (exp_bwd.size() == 0) begin
                    check(1'b0, "R7", "unexpected bwd", s6(bwd_msg), 0);
                end else begin
                    int b;
                    b = exp_bwd.pop_front();
                    check(s6(bwd_msg) == b, "R7", "bwd_msg", s6(bwd_msg), b);
                end
            end
        end
    end

    // Build expectations, drive one node, then time the output phase.
    task automatic send_node(input bit chk, input int msgs[$], input int ch,
                             input int prt, input int pch, input bit grp, input bit gaps);
        int d;
        int cyc;
        d = msgs.size();
        if (!chk) begin
            int tot;
            tot = ch;
            foreach (msgs[i]) tot += msgs[i];
            foreach (msgs[i]) begin
                exp_out.push_back(clip6(tot - msgs[i]));
                exp_last.push_back(i == d - 1);
            end
        end else begin
            int mg;
            bit ng;
            foreach (msgs[i]) begin
                mg = 31;
                ng = 0;
                foreach (msgs[j]) begin
                    if (j != i) begin
                        mg = minv(mg, absv(msgs[j]));
                        ng ^= (msgs[j] < 0);
                    end
                end
                if (!grp) begin
                    mg = minv(mg, absv(ref_fwd));
                    ng ^= (ref_fwd < 0);
                end
                mg = minv(mg, absv(prt));
                ng ^= (prt < 0);
                exp_out.push_back(ng ? -mg : mg);
                exp_last.push_back(i == d - 1);
            end
            mg = absv(prt);
            ng = (prt < 0);
            foreach (msgs[j]) begin
                mg = minv(mg, absv(msgs[j]));
                ng ^= (msgs[j] < 0);
            end
            exp_bwd.push_back(ng ? -mg : mg);
            mg = 31;
            ng = 0;
            foreach (msgs[j]) begin
                mg = minv(mg, absv(msgs[j]));
                ng ^= (msgs[j] < 0);
            end
            if (!grp) begin
                mg = minv(mg, absv(ref_fwd));
                ng ^= (ref_fwd < 0);
            end
            ref_fwd = clip6(pch + (ng ? -mg : mg));
        end

        for (int b = 0; b < d; b++) begin
            @(negedge clk);
            if (gaps && b > 0) begin
                in_valid = 1'b0;
                in_last  = 1'b1;
                in_msg   = 6'd7;
                @(negedge clk);
            end
            while (!in_ready) @(negedge clk);
            in_valid = 1'b1;
            in_msg   = MW'(msgs[b]);
            in_last  = (b == d - 1);
            if (b == 0) begin
                node_kind = chk;
                ch_llr    = MW'(ch);
                grp_first = grp;
                par_rt    = MW'(prt);
                par_ch    = MW'(pch);
            end else begin
                node_kind = !chk;
                ch_llr    = MW'(clip6(-ch + 3));
                grp_first = !grp;
                par_rt    = MW'((prt == 0) ? 13 : -prt);
                par_ch    = MW'(clip6(-pch - 5));
            end
        end
        @(negedge clk);
        in_valid = 1'b0;
        in_last  = 1'b0;
        check(!in_ready, "R2", "in_ready after last", int'(in_ready), 0);
        cyc = 0;
        while (!in_ready) begin
            @(negedge clk);
            cyc++;
        end
        check(cyc == d, "R3", "cycles until ready", cyc, d);
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        #2000000;
        if (!done) begin
            done = 1;
            n_chk++;
            n_fail++;
            $display("FAIL R3 watchdog expired actual=%0d expected=%0d", 1, 0);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        int q[$];
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check(in_ready == 1'b1, "R1", "in_ready", int'(in_ready), 1);
        check(out_valid == 1'b0, "R1", "out_valid", int'(out_valid), 0);
        check(bwd_valid == 1'b0, "R1", "bwd_valid", int'(bwd_valid), 0);

        // R4, R2, R10: small variable node with bubbles and noisy side inputs
        cur_req = "R4";
        q = '{3, -7, 12};
        send_node(1'b0, q, 5, 0, 0, 1'b0, 1'b1);
        q = '{9};
        send_node(1'b0, q, -4, 0, 0, 1'b0, 1'b0);

        // R5: saturation both ways
        cur_req = "R5";
        q = '{31, 31, 31, 31};
        send_node(1'b0, q, 31, 0, 0, 1'b0, 1'b0);
        q = '{-20, -20, -20, -20, -31};
        send_node(1'b0, q, -31, 0, 0, 1'b0, 1'b1);

        // R6, R7, R8, R9: a group of check nodes
        cur_req = "R6";
        q = '{5, -3, 12, 7};
        send_node(1'b1, q, 0, -9, 4, 1'b1, 1'b0);
        cur_req = "R8";
        q = '{-14, 22, 6};
        send_node(1'b1, q, 0, 18, -10, 1'b0, 1'b1);
        q = '{4, 4, 9};
        send_node(1'b1, q, 0, 25, 2, 1'b0, 1'b0);
        // R8: variable node between check nodes leaves the carried value
        cur_req = "R4";
        q = '{1, 2};
        send_node(1'b0, q, 0, 0, 0, 1'b0, 1'b0);
        cur_req = "R8";
        q = '{-11, -12, 30, 0};
        send_node(1'b1, q, 0, -27, 1, 1'b0, 1'b0);
        // R9: carried value of magnitude 1 must not take part at a group start
        cur_req = "R9";
        q = '{15, -16, 20};
        send_node(1'b1, q, 0, 21, 0, 1'b1, 1'b0);
        q = '{8, 9};
        send_node(1'b1, q, 0, 10, 3, 1'b0, 1'b0);

        // R2, R3: full-degree nodes of both kinds
        cur_req = "R4";
        q = {};
        for (int i = 0; i < MD; i++) q.push_back(gen(i, 7));
        send_node(1'b0, q, -2, 0, 0, 1'b0, 1'b0);
        cur_req = "R6";
        q = {};
        for (int i = 0; i < MD; i++) q.push_back(gen(i, 17) == 0 ? 5 : gen(i, 17));
        send_node(1'b1, q, 0, 29, -6, 1'b0, 1'b1);

        @(negedge clk);
        check(exp_out.size() == 0, "R3", "outputs left over", exp_out.size(), 0);
        check(exp_bwd.size() == 0, "R7", "bwd left over", exp_bwd.size(), 0);
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule